// File: doc/BRIEF.md
# Down-Counting Interval Timer

This block is a single timer channel behind a small word-wide register bus. Software places a period value in the load register and writes a control word. The control word holds three fields: an enable, a choice between reloading and free-running, and an interrupt mask. While the timer is enabled, a 32-bit counter steps down by one on every cycle in which the tick-enable input is high.

When the counter is at zero and a tick arrives, the period ends. In reload mode the counter takes the load value again. In free-running mode it wraps to all-ones and keeps counting down. If the mask is clear, the end of a period also sets a pending flag, and the level interrupt output follows that flag. Reading the end-of-interrupt register clears the flag.

The current count can be read back at any time. Because the counter only falls, the bitwise inverse of the count gives software a timestamp that rises steadily.

Top module: `countdown_timer`

## Requirements
- R1: After synchronous reset, the load register, count, control word and pending flag are all zero, and `irq` is low.
- R2: A write to byte offset 0x00 stores the load value, and a write to offset 0x08 stores the control word in bits [2:0]. Both read back at the same offsets: the control word zero-extended, and unmapped offsets read as zero.
- R3: A control write that sets enable (bit 0) while enable is currently clear copies the load register into the counter at that clock edge. A control write while already enabled does not reload the counter.
- R4: While enabled, the count (read at offset 0x04) drops by one on each edge with `tick_en` high and the count non-zero. It holds when `tick_en` is low. Its bitwise inverse therefore rises.
- R5: In reload mode (bit 1 = 1), a tick at count zero loads the load value, so the period is load+1 ticks. Control code 3 is enabled, reload and unmasked.
- R6: In free-running mode (bit 1 = 0), a tick at count zero sets the count to 0xFFFFFFFF. The load value is not taken.
- R7: A period end with the mask (bit 2) clear sets the pending flag. The flag reads as bit 0 of offset 0x10, and `irq` equals pending AND NOT mask.
- R8: A period end with the mask set leaves the pending flag unchanged and `irq` low. Control code 5 is enabled, free-running and masked.
- R9: A read at offset 0x0C returns zero and clears the pending flag at that edge.
- R10: If an end-of-interrupt read and an unmasked period end fall on the same edge, the pending flag ends up set.
- R11: With enable clear (control code 6: disabled, reload, masked), the count holds regardless of `tick_en`, and no interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| tick_en | input | 1 | One-cycle count enable |
| irq | output | 1 | Level interrupt |

## Verification
A wrong count shows up at offset 0x04 on the cycle right after the faulty edge. A reload or wrap error also changes the next period's length, so `irq` rises too early or too late by exactly the error in ticks. A stuck or wrongly cleared pending flag shows on `irq` and on status bit 0 on the next cycle. The reference model runs alongside the design and compares the read data and `irq` after every edge, so the first divergent cycle is reported.

// File: rtl/ctmr_pkg.sv
`timescale 1ns/1ps
package ctmr_pkg;

    // byte offsets of the registers
    localparam int unsigned OFF_LOAD   = 'h00;
    localparam int unsigned OFF_COUNT  = 'h04;
    localparam int unsigned OFF_CTRL   = 'h08;
    localparam int unsigned OFF_EOI    = 'h0C;
    localparam int unsigned OFF_STATUS = 'h10;

    // control word, bit 0 = enable, bit 1 = reload, bit 2 = mask
    typedef struct packed {
        logic irq_mask;
        logic reload;
        logic enable;
    } ctrl_t;

    localparam int unsigned CTRL_W = $bits(ctrl_t);

    // decoded bus access with side effects
    typedef struct packed {
        logic load_wr;
        logic ctrl_wr;
        logic eoi_rd;
    } bus_dec_t;

    function automatic logic off_hit(input logic [31:0] addr, input int unsigned off);
        return addr == off[31:0];
    endfunction

    // a rising enable restarts the counter from the load value
    function automatic logic starts(input ctrl_t cur, input ctrl_t nxt);
        return nxt.enable && !cur.enable;
    endfunction

endpackage

// File: rtl/ctmr_regs.sv
`timescale 1ns/1ps
module ctmr_regs
    import ctmr_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] cnt_i,
    input  logic              pending_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [DATA_W-1:0] load_o,
    output ctrl_t             ctrl_o,
    output logic              start_o,
    output logic              eoi_o
);

    localparam int unsigned PAD_W = (ADDR_W < 32) ? 32 - ADDR_W : 1;

    logic [31:0]       addr_ext;
    bus_dec_t          dec;
    logic [DATA_W-1:0] load_q;
    ctrl_t             ctrl_q;
    ctrl_t             ctrl_wr_val;

    generate
        if (ADDR_W < 32) begin : g_pad
            assign addr_ext = {{PAD_W{1'b0}}, bus_addr};
        end else begin : g_nopad
            assign addr_ext = bus_addr[31:0];
        end
    endgenerate

    always_comb begin
        dec.load_wr = bus_sel &&  bus_we && off_hit(addr_ext, OFF_LOAD);
        dec.ctrl_wr = bus_sel &&  bus_we && off_hit(addr_ext, OFF_CTRL);
        dec.eoi_rd  = bus_sel && !bus_we && off_hit(addr_ext, OFF_EOI);
    end

    assign ctrl_wr_val = ctrl_t'(bus_wdata[CTRL_W-1:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            load_q <= '0;
            ctrl_q <= '0;
        end else begin
            if (dec.load_wr) load_q <= bus_wdata;
            if (dec.ctrl_wr) ctrl_q <= ctrl_wr_val;
        end
    end

    assign start_o = dec.ctrl_wr && starts(ctrl_q, ctrl_wr_val);
    assign eoi_o   = dec.eoi_rd;
    assign load_o  = load_q;
    assign ctrl_o  = ctrl_q;

    always_comb begin
        rdata_o = '0;
        if (off_hit(addr_ext, OFF_LOAD))        rdata_o = load_q;
        else if (off_hit(addr_ext, OFF_COUNT))  rdata_o = cnt_i;
        else if (off_hit(addr_ext, OFF_CTRL))   rdata_o = DATA_W'(ctrl_q);
        else if (off_hit(addr_ext, OFF_STATUS)) rdata_o = DATA_W'(pending_i);
    end

    // R2
    load_store_chk: assert property (@(posedge clk) disable iff (rst)
        dec.load_wr |=> load_q == $past(bus_wdata));

    // R2
    ctrl_store_chk: assert property (@(posedge clk) disable iff (rst)
        dec.ctrl_wr |=> ctrl_q == $past(ctrl_wr_val));

endmodule

// File: rtl/ctmr_counter.sv
`timescale 1ns/1ps
module ctmr_counter #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable_i,
    input  logic              reload_i,
    input  logic              start_i,
    input  logic              tick_i,
    input  logic [DATA_W-1:0] load_i,
    output logic [DATA_W-1:0] cnt_o,
    output logic              expire_o
);

    localparam logic [DATA_W-1:0] WRAP_VAL = '1;

    typedef enum logic [1:0] {
        ST_HOLD,
        ST_START,
        ST_STEP,
        ST_END
    } step_e;

    logic [DATA_W-1:0] cnt_q;
    logic [DATA_W-1:0] cnt_d;
    logic              at_zero;
    step_e             act;

    assign at_zero = (cnt_q == '0);

    always_comb begin
        if (start_i)                          act = ST_START;
        else if (enable_i && tick_i && at_zero) act = ST_END;
        else if (enable_i && tick_i)          act = ST_STEP;
        else                                  act = ST_HOLD;
    end

    always_comb begin
        unique case (act)
            ST_START: cnt_d = load_i;
            ST_STEP:  cnt_d = cnt_q - 1'b1;
            ST_END:   cnt_d = reload_i ? load_i : WRAP_VAL;
            default:  cnt_d = cnt_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign cnt_o    = cnt_q;
    assign expire_o = (act == ST_END);

    // R3
    start_load_chk: assert property (@(posedge clk) disable iff (rst)
        start_i |=> cnt_q == $past(load_i));

    // R4
    step_down_chk: assert property (@(posedge clk) disable iff (rst)
        (enable_i && tick_i && !start_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!enable_i && !start_i) |=> $stable(cnt_q));

    // R5
    reload_val_chk: assert property (@(posedge clk) disable iff (rst)
        (expire_o && reload_i) |=> cnt_q == $past(load_i));

    // R6
    wrap_val_chk: assert property (@(posedge clk) disable iff (rst)
        (expire_o && !reload_i) |=> cnt_q == WRAP_VAL);

endmodule

// File: rtl/ctmr_irq.sv
`timescale 1ns/1ps
module ctmr_irq (
    input  logic clk,
    input  logic rst,
    input  logic expire_i,
    input  logic mask_i,
    input  logic eoi_i,
    output logic pending_o,
    output logic irq_o
);

    logic pend_q;
    logic set_ev;

    assign set_ev = expire_i && !mask_i;

    always_ff @(posedge clk) begin
        if (rst)         pend_q <= 1'b0;
        else if (set_ev) pend_q <= 1'b1;
        else if (eoi_i)  pend_q <= 1'b0;
    end

    assign pending_o = pend_q;
    assign irq_o     = pend_q && !mask_i;

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (expire_i && !mask_i) |=> pend_q);

    // R9
    eoi_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (eoi_i && !(expire_i && !mask_i)) |=> !pend_q);

    // R8
    masked_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (expire_i && mask_i && !eoi_i) |=> $stable(pend_q));

    // R7
    no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
        (!expire_i && !pend_q) |=> !pend_q);

endmodule

// File: rtl/countdown_timer.sv
`timescale 1ns/1ps
module countdown_timer
    import ctmr_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tick_en,
    output logic              irq
);

    logic [DATA_W-1:0] load_w;
    logic [DATA_W-1:0] cnt_w;
    ctrl_t             ctrl_w;
    logic              start_w;
    logic              eoi_w;
    logic              expire_w;
    logic              pending_w;

    ctmr_regs #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cnt_i     (cnt_w),
        .pending_i (pending_w),
        .rdata_o   (bus_rdata),
        .load_o    (load_w),
        .ctrl_o    (ctrl_w),
        .start_o   (start_w),
        .eoi_o     (eoi_w)
    );

    ctmr_counter #(
        .DATA_W (DATA_W)
    ) u_counter (
        .clk      (clk),
        .rst      (rst),
        .enable_i (ctrl_w.enable),
        .reload_i (ctrl_w.reload),
        .start_i  (start_w),
        .tick_i   (tick_en),
        .load_i   (load_w),
        .cnt_o    (cnt_w),
        .expire_o (expire_w)
    );

    ctmr_irq u_irq (
        .clk       (clk),
        .rst       (rst),
        .expire_i  (expire_w),
        .mask_i    (ctrl_w.irq_mask),
        .eoi_i     (eoi_w),
        .pending_o (pending_w),
        .irq_o     (irq)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!irq && cnt_w == '0));

endmodule

// File: tb/countdown_timer_tb.sv
`timescale 1ns/1ps
module countdown_timer_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel = 1'b0;
    logic        we = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        tick = 1'b0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    countdown_timer u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (sel),
        .bus_we    (we),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .tick_en   (tick),
        .irq       (irq)
    );

    // behavioural reference state
    logic [31:0] m_load, m_cnt;
    logic [2:0]  m_ctrl;
    logic        m_pend;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] m_read(input logic [4:0] a);
        case (a)
            5'h00:   return m_load;
            5'h04:   return m_cnt;
            5'h08:   return {29'b0, m_ctrl};
            5'h10:   return {31'b0, m_pend};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [4:0] a);
        case (a)
            5'h04:   return "R4";
            5'h0C:   return "R9";
            5'h10:   return "R7";
            default: return "R2";
        endcase
    endfunction

    // model update on every edge, compare after it
    always begin
        @(posedge clk);
        if (rst) begin
            m_load = '0; m_cnt = '0; m_ctrl = '0; m_pend = 1'b0;
        end else begin
            logic [31:0] old_load;
            logic [2:0]  old_ctrl;
            bit start, fire, eoi;
            old_load = m_load;
            old_ctrl = m_ctrl;
            start = 0; fire = 0;
            eoi = sel && !we && addr == 5'h0C;
            if (sel && we && addr == 5'h00) m_load = wdata;
            if (sel && we && addr == 5'h08) begin
                if (wdata[0] && !old_ctrl[0]) start = 1;
                m_ctrl = wdata[2:0];
            end
            if (start) m_cnt = old_load;
            else if (old_ctrl[0] && tick) begin
                if (m_cnt == 0) begin
                    fire = 1;
                    m_cnt = old_ctrl[1] ? old_load : 32'hFFFF_FFFF;
                end else begin
                    m_cnt = m_cnt - 1;
                end
            end
            if (fire && !old_ctrl[2]) m_pend = 1'b1;
            else if (eoi) m_pend = 1'b0;
        end
        #1;
        if (!rst) begin
            check(irq === (m_pend && !m_ctrl[2]), "R7", {31'b0, irq}, {31'b0, m_pend && !m_ctrl[2]});
            check(rdata === m_read(addr), tag_of(addr), rdata, m_read(addr));
        end
    end

    task automatic step(input logic s, input logic w, input logic [4:0] a,
                        input logic [31:0] d, input logic t);
        @(negedge clk);
        sel = s; we = w; addr = a; wdata = d; tick = t;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        step(1'b1, 1'b1, a, d, 1'b0);
    endtask

    task automatic idle(input int n, input logic t);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 5'h0, 32'h0, t);
    endtask

    task automatic rd_chk(input logic [4:0] a, input logic [31:0] exp, input string tag);
        step(1'b1, 1'b0, a, 32'h0, 1'b0);
        #1;
        check(rdata === exp, tag, rdata, exp);
    endtask

    task automatic irq_chk(input logic exp, input string tag);
        check(irq === exp, tag, {31'b0, irq}, {31'b0, exp});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd_chk(5'h00, 32'h0, "R1");
        irq_chk(1'b0, "R1");
        rd_chk(5'h04, 32'h0, "R1");
        rd_chk(5'h08, 32'h0, "R1");
        rd_chk(5'h10, 32'h0, "R1");
        // R2 register storage
        wr(5'h00, 32'h1234_5678);
        rd_chk(5'h00, 32'h1234_5678, "R2");
        wr(5'h08, 32'h6);
        rd_chk(5'h08, 32'h6, "R2");
        rd_chk(5'h14, 32'h0, "R2");
        // R11 disabled holds
        idle(4, 1'b1);
        rd_chk(5'h04, 32'h0, "R11");
        irq_chk(1'b0, "R11");
        // R3 start loads the counter
        wr(5'h00, 32'd4);
        wr(5'h08, 32'd3);
        rd_chk(5'h04, 32'd4, "R3");
        idle(2, 1'b0);
        rd_chk(5'h04, 32'd4, "R4");
        idle(1, 1'b1);
        rd_chk(5'h04, 32'd3, "R4");
        idle(3, 1'b1);
        rd_chk(5'h04, 32'd0, "R4");
        irq_chk(1'b0, "R7");
        // R5 reload at period end, R7 pending
        idle(1, 1'b1);
        rd_chk(5'h04, 32'd4, "R5");
        irq_chk(1'b1, "R7");
        rd_chk(5'h10, 32'd1, "R7");
        // R9 end-of-interrupt read
        rd_chk(5'h0C, 32'd0, "R9");
        rd_chk(5'h10, 32'd0, "R9");
        irq_chk(1'b0, "R9");
        // R3 no restart while enabled
        idle(1, 1'b1);
        wr(5'h08, 32'd3);
        rd_chk(5'h04, 32'd3, "R3");
        // R10 clear and expiry on one edge
        idle(3, 1'b1);
        rd_chk(5'h04, 32'd0, "R10");
        step(1'b1, 1'b0, 5'h0C, 32'h0, 1'b1);
        rd_chk(5'h10, 32'd1, "R10");
        irq_chk(1'b1, "R10");
        rd_chk(5'h0C, 32'd0, "R9");
        // R6 free-running wrap, R8 masked
        wr(5'h08, 32'd6);
        wr(5'h00, 32'd2);
        wr(5'h08, 32'd5);
        rd_chk(5'h04, 32'd2, "R3");
        idle(3, 1'b1);
        rd_chk(5'h04, 32'hFFFF_FFFF, "R6");
        rd_chk(5'h10, 32'd0, "R8");
        irq_chk(1'b0, "R8");
        idle(1, 1'b1);
        step(1'b1, 1'b0, 5'h04, 32'h0, 1'b0);
        #1;
        check(~rdata === 32'd1, "R4", ~rdata, 32'd1);
        // mixed traffic, compared by the model every cycle
        for (int i = 0; i < 800; i++) begin
            int r;
            logic t;
            r = $urandom_range(0, 99);
            t = ($urandom_range(0, 9) < 7);
            if (r < 8) begin
                int c;
                logic [31:0] code;
                c = $urandom_range(0, 3);
                code = (c == 0) ? 32'd3 : (c == 1) ? 32'd5 : (c == 2) ? 32'd6 : 32'($urandom_range(0, 7));
                step(1'b1, 1'b1, 5'h08, code, t);
            end else if (r < 14) begin
                step(1'b1, 1'b1, 5'h00, 32'($urandom_range(0, 12)), t);
            end else if (r < 24) begin
                step(1'b1, 1'b0, 5'h0C, 32'h0, t);
            end else begin
                logic [4:0] a;
                a = 5'($urandom_range(0, 5) * 4);
                step(1'b1, 1'b0, a, 32'h0, t);
            end
        end
        idle(2, 1'b0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule